// File: doc/BRIEF.md
# Dual-Rate Pacer Divisor Calculator

This block turns two requested pacing intervals, given in nanoseconds, into the load values for a two-stage acquisition pacing clock. A fixed 500 ns oscillator drives one shared prescaler counter. That counter runs as a square-wave generator. Its output clocks two rate-generator counters: one sets the time between conversions and the other sets the time between scans. The block picks one prescaler value for both rates. It then derives both rate divisors from the prescaled base period, using a rounding rule the caller selects. It also reports the intervals that the counters will actually produce once every value has been clamped into the counters' legal range.

Requests arrive on a valid/ready pair. The caller presents both intervals, the rounding mode and one flag per interval that says whether the interval is timer-driven. `req_ready` is high only while the block is idle with no result pending. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and the inputs need to be valid only in that cycle. The work runs through one iterative divider used three times in a row. The result is presented on a valid/ready pair. `res_valid` and every result field stay constant until `res_ready` is seen high, so the consumer can apply back-pressure for as long as it likes. The block accepts nothing new until the result has been taken.

Top module: `pacer_divisor_calc`

## Requirements
- R1: `req_ready` is 1 after reset and whenever no request is in progress and no result is waiting. It is 0 from the cycle after an acceptance until the result has been consumed.
- R2: Once `res_valid` is 1, it and all result outputs stay unchanged while `res_ready` is 0. After a cycle with `res_valid` and `res_ready` both high, `res_valid` is 0 and `req_ready` is 1.
- R3: The reference interval is `scan_ns` if `scan_timed` is 1, otherwise `conv_ns` if `conv_timed` is 1, otherwise 0. `res_presc` is ceil(reference / 32768000) clamped to [2, 65536]. A reference of 0 gives 2.
- R4: The base period is 500 ns times `res_presc`.
- R5: With `round_mode` 2'b00 or 2'b11 (nearest), a raw rate divisor is floor((interval + floor(base/2)) / base).
- R6: With `round_mode` 2'b01 (up), a raw rate divisor is floor((interval + base - 1) / base).
- R7: With `round_mode` 2'b10 (down), a raw rate divisor is floor(interval / base).
- R8: Each reported rate divisor of a timed interval is its raw value clamped to [2, 65536].
- R9: Each reported corrected interval of a timed interval equals base times its clamped divisor, as a 33-bit value.
- R10: For an interval whose timed flag is 0, the reported divisor and corrected interval are both 0.
- R11: `res_valid` first reads 1 exactly 3*(PW+3) rising edges after the accepting edge. With default parameters this is 105 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| conv_ns | input | PW | Requested conversion interval, ns |
| scan_ns | input | PW | Requested scan interval, ns |
| round_mode | input | 2 | 00/11 nearest, 01 up, 10 down |
| conv_timed | input | 1 | Conversion interval is timer-driven |
| scan_timed | input | 1 | Scan interval is timer-driven |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_presc | output | CW+1 | Shared prescaler divisor |
| res_conv_div | output | CW+1 | Conversion rate divisor |
| res_scan_div | output | CW+1 | Scan rate divisor |
| res_conv_ns | output | PW+1 | Corrected conversion interval, ns |
| res_scan_ns | output | PW+1 | Corrected scan interval, ns |

## Verification
The bench crosses a set of conversion intervals with a set of scan intervals, over all four rounding codes and all four combinations of the timed flags. Conversion intervals of 0, 1 and 999 ns fall below the lower clamp, while the full 32-bit value pushes above the upper clamp. Scan intervals at and one past multiples of 32768000 ns show whether the prescaler rounds up at the exact step boundary. Running every rounding code on the same operands tells the three rounding formulas apart. The flag combinations show which interval chooses the prescaler and whether untimed outputs are forced to zero. Back-pressure is applied on the first requests to confirm the results hold steady until they are consumed.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_UP      = 2'b01,
    RND_DOWN    = 2'b10,
    RND_NEAR_B  = 2'b11
  } round_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_CONV,
    ST_SCAN,
    ST_OUT
  } calc_state_e;
endpackage

// File: rtl/pacer_itdiv.sv
// Restoring divider: one quotient bit per cycle, done pulses the cycle after the last bit.
module pacer_itdiv #(
  parameter int NW = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [NW-1:0] divisor,
  output logic          done,
  output logic [NW-1:0] quotient
);
  localparam int CNT_W = $clog2(NW + 1);

  logic [NW-1:0]    rem_q, quo_q, dvs_q, dvd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [NW:0]      shifted;
  logic             fits;

  assign shifted  = {rem_q, quo_q[NW-1]};
  assign fits     = shifted >= {1'b0, dvs_q};
  assign quotient = quo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      dvd_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q  <= '0;
        quo_q  <= dividend;
        dvd_q  <= dividend;
        dvs_q  <= divisor;
        cnt_q  <= CNT_W'(NW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (fits) begin
          rem_q <= NW'(shifted - {1'b0, dvs_q});
          quo_q <= {quo_q[NW-2:0], 1'b1};
        end else begin
          rem_q <= shifted[NW-1:0];
          quo_q <= {quo_q[NW-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  // R3 R5 R6 R7: the quotient and remainder reconstruct the latched dividend exactly
  p_exact_quot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((2*NW)'(quo_q) * (2*NW)'(dvs_q) + (2*NW)'(rem_q) == (2*NW)'(dvd_q))
             && (rem_q < dvs_q));
endmodule

// File: rtl/pacer_clamp.sv
module pacer_clamp #(
  parameter int IW = 34,
  parameter int OW = 17,
  parameter longint LO = 2,
  parameter longint HI = 65536
) (
  input  logic [IW-1:0] val,
  output logic [OW-1:0] clamped
);
  localparam logic [IW-1:0] LO_V = IW'(LO);
  localparam logic [IW-1:0] HI_V = IW'(HI);

  always_comb begin
    if (val < LO_V)      clamped = OW'(LO);
    else if (val > HI_V) clamped = OW'(HI);
    else                 clamped = val[OW-1:0];
  end
endmodule

// File: rtl/pacer_divisor_calc.sv
module pacer_divisor_calc
  import pacer_pkg::*;
#(
  parameter int PW     = 32,
  parameter int CW     = 16,
  parameter int OSC_NS = 500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [PW-1:0] conv_ns,
  input  logic [PW-1:0] scan_ns,
  input  logic [1:0]    round_mode,
  input  logic          conv_timed,
  input  logic          scan_timed,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [CW:0]   res_presc,
  output logic [CW:0]   res_conv_div,
  output logic [CW:0]   res_scan_div,
  output logic [PW:0]   res_conv_ns,
  output logic [PW:0]   res_scan_ns
);
  localparam int     NW      = PW + 1;
  localparam int     DW      = CW + 1;
  localparam int     PRODW   = NW + DW;
  localparam longint MAXDIV  = longint'(1) << CW;
  localparam longint PRE_L   = longint'(OSC_NS) * MAXDIV;
  localparam logic [NW-1:0] PRE_DVS = NW'(PRE_L);

  calc_state_e   state_q;
  logic [PW-1:0] conv_q, scan_q;
  round_e        mode_q;
  logic          conv_t_q, scan_t_q;
  logic [DW-1:0] presc_q, cdiv_q, sdiv_q;
  logic          div_start_q, div_done;
  logic [NW-1:0] div_dvd, div_dvs, div_quo, base, adj, ref_m1;
  logic [PW-1:0] ref_ns, period_sel;
  logic [NW:0]   clamp_in;
  logic [DW-1:0] clamp_out;
  logic [PRODW-1:0] prod_c, prod_s;

  assign req_ready = (state_q == ST_IDLE);
  assign res_valid = (state_q == ST_OUT);

  // Prescaler reference: the scan interval wins when it is timed.
  assign ref_ns = scan_t_q ? scan_q : (conv_t_q ? conv_q : '0);
  assign ref_m1 = (ref_ns == '0) ? '0 : NW'(ref_ns) - NW'(1);
  assign base   = NW'(OSC_NS) * NW'(presc_q);

  always_comb begin
    unique case (mode_q)
      RND_UP:   adj = base - NW'(1);
      RND_DOWN: adj = '0;
      default:  adj = base >> 1;
    endcase
  end

  assign period_sel = (state_q == ST_CONV) ? conv_q : scan_q;
  assign div_dvd    = (state_q == ST_PRE) ? ref_m1 : (NW'(period_sel) + adj);
  assign div_dvs    = (state_q == ST_PRE) ? PRE_DVS : base;
  assign clamp_in   = {1'b0, div_quo} + ((state_q == ST_PRE) ? (NW+1)'(1) : '0);

  pacer_itdiv #(.NW(NW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start_q),
    .dividend (div_dvd),
    .divisor  (div_dvs),
    .done     (div_done),
    .quotient (div_quo)
  );

  pacer_clamp #(.IW(NW + 1), .OW(DW), .LO(2), .HI(MAXDIV)) u_clamp (
    .val     (clamp_in),
    .clamped (clamp_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      conv_q      <= '0;
      scan_q      <= '0;
      mode_q      <= RND_NEAREST;
      conv_t_q    <= 1'b0;
      scan_t_q    <= 1'b0;
      presc_q     <= DW'(2);
      cdiv_q      <= '0;
      sdiv_q      <= '0;
      div_start_q <= 1'b0;
    end else begin
      div_start_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          conv_q      <= conv_ns;
          scan_q      <= scan_ns;
          mode_q      <= round_e'(round_mode);
          conv_t_q    <= conv_timed;
          scan_t_q    <= scan_timed;
          div_start_q <= 1'b1;
          state_q     <= ST_PRE;
        end
        ST_PRE: if (div_done) begin
          presc_q     <= clamp_out;
          div_start_q <= 1'b1;
          state_q     <= ST_CONV;
        end
        ST_CONV: if (div_done) begin
          cdiv_q      <= clamp_out;
          div_start_q <= 1'b1;
          state_q     <= ST_SCAN;
        end
        ST_SCAN: if (div_done) begin
          sdiv_q  <= clamp_out;
          state_q <= ST_OUT;
        end
        ST_OUT: if (res_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign prod_c = PRODW'(base) * PRODW'(cdiv_q);
  assign prod_s = PRODW'(base) * PRODW'(sdiv_q);

  assign res_presc    = presc_q;
  assign res_conv_div = conv_t_q ? cdiv_q : '0;
  assign res_scan_div = scan_t_q ? sdiv_q : '0;
  assign res_conv_ns  = conv_t_q ? prod_c[NW-1:0] : '0;
  assign res_scan_ns  = scan_t_q ? prod_s[NW-1:0] : '0;

  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_hold_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_presc)
      && $stable(res_conv_div) && $stable(res_scan_div)
      && $stable(res_conv_ns) && $stable(res_scan_ns));

  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (req_ready && !res_valid));

  p_base_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV || state_q == ST_SCAN) |-> (base >= NW'(2 * OSC_NS)));

  p_div_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && conv_t_q) |-> (res_conv_div >= DW'(2) && res_conv_div <= DW'(MAXDIV)));

  p_untimed_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !scan_t_q) |-> (res_scan_div == '0 && res_scan_ns == '0));
endmodule

// File: tb/pacer_divisor_calc_tb.sv
module pacer_divisor_calc_tb;
  localparam int PW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [PW-1:0] conv_ns = '0, scan_ns = '0;
  logic [1:0]    round_mode = '0;
  logic          conv_timed = 1'b0, scan_timed = 1'b0;
  logic          res_valid;
  logic          res_ready = 1'b0;
  logic [CW:0]   res_presc, res_conv_div, res_scan_div;
  logic [PW:0]   res_conv_ns, res_scan_ns;

  int n_total = 0;
  int n_fail  = 0;
  longint cyc = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pacer_divisor_calc #(.PW(PW), .CW(CW), .OSC_NS(500)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .conv_ns(conv_ns), .scan_ns(scan_ns), .round_mode(round_mode),
    .conv_timed(conv_timed), .scan_timed(scan_timed),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_presc(res_presc), .res_conv_div(res_conv_div), .res_scan_div(res_scan_div),
    .res_conv_ns(res_conv_ns), .res_scan_ns(res_scan_ns)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint clampv(input longint v);
    if (v < 2) return 2;
    if (v > 65536) return 65536;
    return v;
  endfunction

  function automatic longint raw_div(input longint p, input longint base, input int m);
    if (m == 1) return (p + base - 1) / base;
    if (m == 2) return p / base;
    return (p + base / 2) / base;
  endfunction

  function automatic string rate_tag(input longint raw, input int m);
    if (raw < 2 || raw > 65536) return "R8";
    if (m == 1) return "R6";
    if (m == 2) return "R7";
    return "R5";
  endfunction

  task automatic run_one(input longint c, input longint s, input int m,
                         input bit ct, input bit st, input int hold);
    longint refv, presc, base, rc, rs, ec, es, c0;
    conv_ns = PW'(c); scan_ns = PW'(s); round_mode = 2'(m);
    conv_timed = ct; scan_timed = st;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    c0 = cyc;
    req_valid = 1'b0;
    if (hold > 0) chk("R1 busy after accept", longint'(req_ready), 0);
    while (!res_valid) @(negedge clk);
    chk("R11 latency", cyc - c0, 3 * (PW + 3));
    refv  = st ? s : (ct ? c : 0);
    presc = clampv(refv == 0 ? 1 : (refv - 1) / 32768000 + 1);
    base  = 500 * presc;
    rc = raw_div(c, base, m);
    rs = raw_div(s, base, m);
    ec = clampv(rc);
    es = clampv(rs);
    chk("R3 prescaler", longint'(res_presc), presc);
    chk(ct ? rate_tag(rc, m) : "R10", longint'(res_conv_div), ct ? ec : 0);
    chk(st ? rate_tag(rs, m) : "R10", longint'(res_scan_div), st ? es : 0);
    chk(ct ? "R4 R9 conv period" : "R10", longint'(res_conv_ns), ct ? base * ec : 0);
    chk(st ? "R4 R9 scan period" : "R10", longint'(res_scan_ns), st ? base * es : 0);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk("R2 valid held", longint'(res_valid), 1);
      chk("R2 divisor held", longint'(res_scan_div), st ? es : 0);
      chk("R1 not ready while pending", longint'(req_ready), 0);
    end
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    res_ready = 1'b0;
    chk("R2 valid cleared", longint'(res_valid), 0);
    chk("R1 ready again", longint'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", longint'(req_ready), 1);
    chk("R2 reset valid", longint'(res_valid), 0);
    begin
      longint cl[6] = '{0, 1, 999, 1000, 123457, 64'hFFFF_FFFF};
      longint sl[6] = '{0, 2000, 32768000, 32768001, 98304001, 64'hFFFF_FFFF};
      int first = 1;
      for (int ci = 0; ci < 6; ci++)
        for (int si = 0; si < 6; si++)
          for (int m = 0; m < 4; m++)
            for (int f = 0; f < 4; f++) begin
              run_one(cl[ci], sl[si], m, f[0], f[1], first ? 3 : 0);
              first = 0;
            end
    end
    done_flag = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule